// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits on the device side of a flash read port and decides which word goes onto the data pins, and when. A 16-bit read configuration word, `rcfg`, controls it. When the read-mode bit is clear, the start address is captured when address-valid rises. After a selectable number of clocks, words from the array come out in linear order. Each word is held for one or two clocks. The burst either wraps inside an aligned block of 4, 8 or 16 words or runs on without wrapping. When the read-mode bit is set, the block acts as a plain asynchronous port. The data pins then show the array word at the address inputs.

The array is modelled outside the block. The block presents `fetch_addr` and expects `fetch_data` back in the same cycle. A WAIT output marks the clocks in which the data pins do not yet hold a valid word. The configuration word sets WAIT's active level and whether WAIT is released one clock early. It also selects whether data and WAIT change on the rising or the falling clock edge. The pins are never tristated inside the block. Instead, `dq_oe` and `wait_oe` tell the pad drivers when to float them.

The control is a three-state machine:

- IDLE goes to LATENCY on a capture.
- LATENCY goes to DATA on the clock that ends the latency count.
- LATENCY or DATA goes back to LATENCY on a new capture, which restarts the burst.
- Any state goes to IDLE while chip enable is high.

Top module: `burst_read_seq`

## Requirements
- R1: With `rcfg[15]`=1, no burst starts. While `ce_n` and `oe_n` are low, `dq` equals the array word at `addr_in` in the same cycle, and `wait_o` sits at its inactive level.
- R2: With `rcfg[15]`=0 and `ce_n` low, a capture happens on a rising `clk` edge that samples `adv_n` high after sampling it low at the previous edge. The capture latches `addr_in` and `rcfg`. Latency code `rcfg[13:11]` = 010, 011, 100 or 101 gives L = 2, 3, 4 or 5. The first word appears after the L-th rising edge following the capture edge.
- R3: Every other latency code, including the reserved codes 001 and 111, gives L = 5.
- R4: `rcfg[10]`=1 makes WAIT active high. `rcfg[10]`=0 makes it active low.
- R5: WAIT becomes active at the capture edge. With `rcfg[8]`=0 it is released at the edge that brings the first word. With `rcfg[8]`=1 it is released one edge earlier. WAIT is never active while words are flowing.
- R6: `rcfg[9]`=0 holds each word for one clock. `rcfg[9]`=1 holds each word for two clocks.
- R7: With `rcfg[6]`=1, data and WAIT change just after a rising edge. With `rcfg[6]`=0, they change at the following falling edge.
- R8: With `rcfg[3]`=0, length codes `rcfg[2:0]` = 001, 010 and 011 give 4, 8 and 16 words. The address counts up modulo that length inside the aligned block containing the start address, and keeps doing so for as long as the burst runs.
- R9: With `rcfg[3]`=1, or with any other length code (111 is continuous), the address simply increments and wraps only at the end of the address space.
- R10: While `ce_n` is high, `dq_oe` and `wait_oe` are low and the burst is abandoned. When `ce_n` goes low again without a new capture, WAIT is inactive and `dq` reads zero in synchronous mode. While `oe_n` is high, `dq_oe` is low but `wait_oe` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low; a rising transition starts a burst |
| oe_n | input | 1 | Output enable, active low |
| rcfg | input | 16 | Read configuration word |
| addr_in | input | AW | Start or asynchronous read address |
| fetch_addr | output | AW | Word address presented to the array |
| fetch_data | input | DW | Array word for `fetch_addr`, same cycle |
| dq | output | DW | Data toward the pads |
| dq_oe | output | 1 | Data pad drive enable |
| wait_o | output | 1 | WAIT level toward the pad |
| wait_oe | output | 1 | WAIT pad drive enable |

## Verification
Counting from the capture edge E0, WAIT is due after E0. It falls after E(L-1) when the early-release bit is set, and after E(L) otherwise. Word k is due after E(L + k·H), where H is the hold length. The bench therefore waits for each rising edge and samples two time units before the next one. That point falls after both the rising-edge and the falling-edge launch, so one expected-value model serves both modes. The edge-select test instead samples one unit after the data edge, where the two modes must differ. Asynchronous reads and the enable outputs are combinational, so they are checked two time units after the input changes.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

    localparam int RCW     = 16;
    localparam int LCW     = 3;
    localparam int LAT_MAX = 5;

    localparam int BIT_ASYNC  = 15;
    localparam int BIT_LAT_HI = 13;
    localparam int BIT_LAT_LO = 11;
    localparam int BIT_WPOL   = 10;
    localparam int BIT_HOLD   = 9;
    localparam int BIT_LEAD   = 8;
    localparam int BIT_RISE   = 6;
    localparam int BIT_NOWRAP = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } brst_state_e;

    typedef struct packed {
        logic       hold2;
        logic       lead;
        logic       nowrap;
        logic [2:0] len_code;
    } burst_cfg_t;

    function automatic logic [LCW-1:0] decode_latency(input logic [LCW-1:0] code);
        logic [LCW-1:0] clks;
        case (code)
            3'b010:  clks = 3'd2;
            3'b011:  clks = 3'd3;
            3'b100:  clks = 3'd4;
            3'b101:  clks = 3'd5;
            default: clks = LCW'(LAT_MAX);
        endcase
        return clks;
    endfunction

    function automatic burst_cfg_t pick_cfg(input logic [RCW-1:0] w);
        burst_cfg_t c;
        c.hold2    = w[BIT_HOLD];
        c.lead     = w[BIT_LEAD];
        c.nowrap   = w[BIT_NOWRAP];
        c.len_code = w[2:0];
        return c;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    len_code,
    input  logic          nowrap,
    output logic [AW-1:0] nxt
);
    localparam int NLEN = 3;

    logic [AW-1:0] inc;
    logic [AW-1:0] masks [NLEN];

    generate
        for (genvar g = 0; g < NLEN; g++) begin : g_mask
            assign masks[g] = AW'((1 << (g + 2)) - 1);
        end
    endgenerate

    always_comb begin
        inc = cur + AW'(1);
        nxt = inc;
        if (!nowrap) begin
            case (len_code)
                3'b001:  nxt = (cur & ~masks[0]) | (inc & masks[0]);
                3'b010:  nxt = (cur & ~masks[1]) | (inc & masks[1]);
                3'b011:  nxt = (cur & ~masks[2]) | (inc & masks[2]);
                default: nxt = inc;
            endcase
        end
    end
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_read_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             adv_n,
    input  logic             sync_en,
    input  logic [LCW-1:0]   lat_code,
    input  burst_cfg_t       cfg_in,
    output brst_state_e      state,
    output burst_cfg_t       cfg_q,
    output logic             load,
    output logic             step,
    output logic             wait_act,
    output logic             data_on
);
    brst_state_e    state_n;
    logic           adv_prev;
    logic [LCW-1:0] lat_cnt;
    logic           hold_ph;
    logic           capture;

    assign capture = !ce_n && !adv_prev && adv_n && sync_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        if (ce_n) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (capture) state_n = ST_LAT;
                ST_LAT: begin
                    if (capture)                 state_n = ST_LAT;
                    else if (lat_cnt == LCW'(1)) state_n = ST_DATA;
                end
                ST_DATA: if (capture) state_n = ST_LAT;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adv_prev <= 1'b1;
            lat_cnt  <= '0;
            hold_ph  <= 1'b0;
            cfg_q    <= '0;
        end else begin
            adv_prev <= adv_n;
            if (capture) begin
                cfg_q   <= cfg_in;
                lat_cnt <= decode_latency(lat_code);
                hold_ph <= 1'b0;
            end else if (state == ST_LAT) begin
                lat_cnt <= lat_cnt - LCW'(1);
                hold_ph <= 1'b0;
            end else if (step) begin
                hold_ph <= 1'b0;
            end else if (state == ST_DATA) begin
                hold_ph <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load     = capture;
        data_on  = (state == ST_DATA);
        step     = (state == ST_DATA) && (!cfg_q.hold2 || hold_ph);
        wait_act = (state == ST_LAT) && !(cfg_q.lead && lat_cnt == LCW'(1));
    end
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_mode,
    input  logic          async_mode,
    input  logic          wait_pol,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [DW-1:0] core_data,
    input  logic [DW-1:0] async_data,
    input  logic          core_wait,
    output logic [DW-1:0] dq,
    output logic          dq_oe,
    output logic          wait_o,
    output logic          wait_oe
);
    logic [DW-1:0] data_fall;
    logic          wait_fall;
    logic          wait_sel;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_fall <= '0;
            wait_fall <= 1'b0;
        end else begin
            data_fall <= core_data;
            wait_fall <= core_wait;
        end
    end

    always_comb begin
        if (async_mode) begin
            dq       = async_data;
            wait_sel = 1'b0;
        end else if (rise_mode) begin
            dq       = core_data;
            wait_sel = core_wait;
        end else begin
            dq       = data_fall;
            wait_sel = wait_fall;
        end
        wait_o  = wait_sel ? wait_pol : !wait_pol;
        dq_oe   = !ce_n && !oe_n;
        wait_oe = !ce_n;
    end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_read_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_n,
    input  logic           adv_n,
    input  logic           oe_n,
    input  logic [RCW-1:0] rcfg,
    input  logic [AW-1:0]  addr_in,
    output logic [AW-1:0]  fetch_addr,
    input  logic [DW-1:0]  fetch_data,
    output logic [DW-1:0]  dq,
    output logic           dq_oe,
    output logic           wait_o,
    output logic           wait_oe
);
    brst_state_e   st;
    burst_cfg_t    cfg_live;
    burst_cfg_t    cfg_q;
    logic          load;
    logic          step;
    logic          core_wait;
    logic          data_on;
    logic          async_mode;
    logic [AW-1:0] baddr;
    logic [AW-1:0] baddr_nxt;
    logic [DW-1:0] core_data;
    logic          unused_cfg_bits;

    assign async_mode      = rcfg[BIT_ASYNC];
    assign cfg_live        = pick_cfg(rcfg);
    assign unused_cfg_bits = ^{rcfg[14], rcfg[7], rcfg[5:4]};

    burst_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .sync_en  (!async_mode),
        .lat_code (rcfg[BIT_LAT_HI:BIT_LAT_LO]),
        .cfg_in   (cfg_live),
        .state    (st),
        .cfg_q    (cfg_q),
        .load     (load),
        .step     (step),
        .wait_act (core_wait),
        .data_on  (data_on)
    );

    burst_addr_gen #(.AW(AW)) u_agen (
        .cur      (baddr),
        .len_code (cfg_q.len_code),
        .nowrap   (cfg_q.nowrap),
        .nxt      (baddr_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    baddr <= '0;
        else if (load) baddr <= addr_in;
        else if (step) baddr <= baddr_nxt;
    end

    assign fetch_addr = async_mode ? addr_in : baddr;
    assign core_data  = data_on ? fetch_data : '0;

    burst_out_stage #(.DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_mode  (rcfg[BIT_RISE]),
        .async_mode (async_mode),
        .wait_pol   (rcfg[BIT_WPOL]),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .core_data  (core_data),
        .async_data (fetch_data),
        .core_wait  (core_wait),
        .dq         (dq),
        .dq_oe      (dq_oe),
        .wait_o     (wait_o),
        .wait_oe    (wait_oe)
    );
endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk
    import burst_read_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          adv_n,
    input logic          rm,
    input brst_state_e   st,
    input logic          load,
    input logic          step,
    input logic          hold2,
    input logic [2:0]    len_code,
    input logic          nowrap,
    input logic [AW-1:0] baddr,
    input logic          core_wait,
    input logic          dq_oe,
    input logic          wait_oe
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_capture_to_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ce_n && !rm && $rose(adv_n)) |=> (st == ST_LAT || ce_n))
        else $error("capture did not enter latency");

    assert_no_wait_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> !core_wait)
        else $error("WAIT active while words flow");

    assert_hold_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hold2) |=> !step)
        else $error("two-clock hold advanced early");

    assert_wrap_four_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !nowrap && len_code == 3'b001) |=>
            (baddr[AW-1:2] == $past(baddr[AW-1:2]) &&
             baddr[1:0] == $past(baddr[1:0]) + 2'd1))
        else $error("4-word wrap left its block");

    assert_deselect_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dq_oe && !wait_oe))
        else $error("pads driven while deselected");

    assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (st == ST_IDLE))
        else $error("burst survived deselect");
endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .adv_n     (adv_n),
    .rm        (rcfg[15]),
    .st        (st),
    .load      (load),
    .step      (step),
    .hold2     (cfg_q.hold2),
    .len_code  (cfg_q.len_code),
    .nowrap    (cfg_q.nowrap),
    .baddr     (baddr),
    .core_wait (core_wait),
    .dq_oe     (dq_oe),
    .wait_oe   (wait_oe)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;
    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int NVEC  = 6;

    // {cfg[15:0], start address[15:0], samples[7:0]}
    localparam logic [39:0] VECS [NVEC] = '{
        {16'h14C1, 16'h0012, 8'd10},
        {16'h1BC2, 16'h0105, 8'd14},
        {16'h2D83, 16'h003D, 8'd16},
        {16'h3CC9, 16'h00FE, 8'd10},
        {16'h2287, 16'hFFFE, 8'd12},
        {16'h0DC2, 16'h0027, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [15:0]   rcfg = 16'h8400;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] fetch_addr;
    logic [DW-1:0] fetch_data;
    logic [DW-1:0] dq;
    logic          dq_oe, wait_o, wait_oe;
    int            n_run = 0;
    int            n_fail = 0;
    logic          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign fetch_data = fetch_addr ^ 16'hA5C3;

    burst_read_seq uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
        .rcfg(rcfg), .addr_in(addr_in), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .dq(dq), .dq_oe(dq_oe),
        .wait_o(wait_o), .wait_oe(wait_oe)
    );

    function automatic logic [15:0] word_at(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    function automatic int lat_of(input logic [2:0] c);
        case (c)
            3'b010:  return 2;
            3'b011:  return 3;
            3'b100:  return 4;
            3'b101:  return 5;
            default: return 5;
        endcase
    endfunction

    function automatic logic [15:0] addr_seq(input logic [15:0] s, input logic [15:0] c, input int k);
        int blen;
        logic [15:0] m;
        blen = 0;
        if (!c[3]) begin
            case (c[2:0])
                3'b001:  blen = 4;
                3'b010:  blen = 8;
                3'b011:  blen = 16;
                default: blen = 0;
            endcase
        end
        if (blen == 0) return s + 16'(k);
        m = 16'(blen - 1);
        return (s & ~m) | ((s + 16'(k)) & m);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // leaves adv_n rising just before edge E0
    task automatic begin_burst(input logic [15:0] c, input logic [15:0] a);
        @(posedge clk); #1;
        rcfg = c; addr_in = a; ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0;
        @(posedge clk); #1;
        adv_n = 1'b1;
    endtask

    task automatic end_burst();
        @(posedge clk); #1;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic run_burst(input logic [15:0] c, input logic [15:0] a, input int n);
        int lat, hold, lead;
        logic wp;
        lat  = lat_of(c[13:11]);
        hold = c[9] ? 2 : 1;
        lead = c[8] ? 1 : 0;
        wp   = c[10];
        begin_burst(c, a);
        for (int i = 0; i < n; i++) begin
            logic act;
            logic [15:0] ew;
            @(posedge clk); #(CLK_P - 2);   // state after edge E(i)
            act = (i < lat - lead);
            check(wait_o == (act ? wp : !wp), "R4 R5 WAIT level", {31'd0, wait_o}, {31'd0, act ? wp : !wp});
            if (i >= lat) begin
                ew = word_at(addr_seq(a, c, (i - lat) / hold));
                check(dq == ew, "R2 R3 R6 R7 R8 R9 burst word", {16'd0, dq}, {16'd0, ew});
            end
        end
        end_burst();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state, R10: deselected pads float
        #(CLK_P * 2 + 1);
        check(dq_oe == 1'b0, "R10 reset dq_oe", {31'd0, dq_oe}, 32'd0);
        check(wait_oe == 1'b0, "R10 reset wait_oe", {31'd0, wait_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: asynchronous single-word reads
        @(posedge clk); #1;
        rcfg = 16'h8400; ce_n = 1'b0; oe_n = 1'b0; addr_in = 16'h1234;
        #2;
        check(dq == word_at(16'h1234), "R1 async word", {16'd0, dq}, {16'd0, word_at(16'h1234)});
        check(wait_o == 1'b0, "R1 async WAIT inactive", {31'd0, wait_o}, 32'd0);
        check(dq_oe == 1'b1, "R1 async dq_oe", {31'd0, dq_oe}, 32'd1);
        addr_in = 16'h0777;
        #2;
        check(dq == word_at(16'h0777), "R1 async follows address", {16'd0, dq}, {16'd0, word_at(16'h0777)});
        @(posedge clk); #1; adv_n = 1'b0;
        @(posedge clk); #1; adv_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(dq == word_at(16'h0777), "R1 no burst in async", {16'd0, dq}, {16'd0, word_at(16'h0777)});
        check(wait_o == 1'b0, "R1 WAIT stays inactive", {31'd0, wait_o}, 32'd0);
        end_burst();

        // table-driven bursts
        for (int v = 0; v < NVEC; v++) begin
            run_burst(VECS[v][39:24], VECS[v][23:8], int'(VECS[v][7:0]));
        end

        // R7: falling-edge launch lags the rising edge by half a clock
        begin_burst(16'h1481, 16'h0040);
        repeat (3) @(posedge clk);      // E0, E1, E2
        #1;
        check(dq == 16'h0000, "R7 falling mode not yet launched", {16'd0, dq}, 32'd0);
        #5;
        check(dq == word_at(16'h0040), "R7 falling mode launched", {16'd0, dq}, {16'd0, word_at(16'h0040)});
        end_burst();
        begin_burst(16'h14C1, 16'h0040);
        repeat (3) @(posedge clk);
        #1;
        check(dq == word_at(16'h0040), "R7 rising mode launched", {16'd0, dq}, {16'd0, word_at(16'h0040)});
        end_burst();

        // R10: output enable and chip enable effects
        begin_burst(16'h14C1, 16'h0012);
        repeat (5) @(posedge clk);
        #1;
        oe_n = 1'b1;
        #1;
        check(dq_oe == 1'b0, "R10 oe_n high floats data", {31'd0, dq_oe}, 32'd0);
        check(wait_oe == 1'b1, "R10 oe_n high keeps WAIT driven", {31'd0, wait_oe}, 32'd1);
        ce_n = 1'b1; oe_n = 1'b0;
        #1;
        check(dq_oe == 1'b0, "R10 ce_n high floats data", {31'd0, dq_oe}, 32'd0);
        check(wait_oe == 1'b0, "R10 ce_n high floats WAIT", {31'd0, wait_oe}, 32'd0);
        @(posedge clk); #1;
        ce_n = 1'b0;
        repeat (2) begin
            @(posedge clk); #(CLK_P - 2);
            check(wait_o == 1'b0, "R10 WAIT inactive after abandon", {31'd0, wait_o}, 32'd0);
            check(dq == 16'h0000, "R10 no burst resumes", {16'd0, dq}, 32'd0);
        end
        end_burst();

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule